// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator

This block makes a pulse-width modulated output from a free-running 16-bit period counter. Software writes a period and a pulse width into staging registers. The counter and the output comparator use a separate pair of active registers. The active pair takes the staged values only when a new period starts, so no output cycle ever mixes an old setting with a new one. A width of zero holds the output low. A width at or above the period holds it high. In both cases the counter keeps running, and any move into or out of these levels waits for a period start.

Writes use a 16-bit port with a two-bit address. There is also a 32-bit port that stages period and width in one cycle. If that 32-bit write lands on the very cycle a period ends, the reload at that boundary is skipped. The following period then runs on the old active values, and the new pair takes effect one period later.

Each period start sets a status flag that invites software to stage the next values. While the flag is set, an interrupt request is raised at a programmable 3-bit level, and level zero disables it. A freeze input stops the counter in place. A select input divides the counting clock by 1 to 4.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset the output is low, the flag and interrupt request are low, the counter is 0, the active period is RST_PER (default 16) and the active width is 0.
- R2: The counter advances by one on each counting tick and returns to 0 on the tick where it equals the active period minus one; that tick is a period boundary.
- R3: The output is high exactly while the counter is below the active width. Width 0 gives a constantly low output and a width at or above the period gives a constantly high one, while the counter keeps running.
- R4: A 16-bit write with address 0 stages the period and address 1 stages the width. The output and the active values are unchanged until the next boundary, where the staged words are copied.
- R5: A 32-bit write stages the period from bits 31:16 and the width from bits 15:0. Both take effect together at the next boundary.
- R6: A 32-bit write in the same cycle as a boundary cancels that boundary's reload. The next period uses the old active values, and the new pair loads at the boundary after that.
- R7: Every boundary sets the flag. A write to address 2 with bit 3 equal to 0 clears it, and a write with bit 3 equal to 1 leaves it alone. A boundary in the same cycle as a clear leaves the flag set.
- R8: A write to address 2 sets the interrupt level from bits 2:0. The request is high while the flag is set and the level is nonzero, and irq_level shows the level while the request is high and 0 otherwise.
- R9: While freeze is high the counter and the prescaler hold their values. Counting resumes from the held value once freeze drops.
- R10: presc_sel value s makes one counting tick every s+1 clocks, so the values 1, 2 and 3 divide by 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze | input | 1 | Holds the counter while high |
| presc_sel | input | 2 | Clock divide select, ratio = value + 1 |
| wr_en | input | 1 | 16-bit register write strobe |
| wr_addr | input | 2 | 0 period, 1 width, 2 control |
| wr_data | input | 16 | 16-bit write data |
| wr32_en | input | 1 | Combined period and width write strobe |
| wr32_data | input | 32 | Period in 31:16, width in 15:0 |
| pwm_out | output | 1 | Modulated output |
| count | output | 16 | Current period counter |
| flag | output | 1 | Period-start status flag |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Level of the active request, 0 when idle |

## Verification
Two pairs of events can fall in one cycle here. A combined write can arrive on the cycle that ends a period, and a flag clear can arrive on the cycle that sets the flag again. The bench provokes each case on purpose. It watches the counter at the falling edge and drives the write when the counter sits one step short of its wrap. A combined write is judged by measuring the high time and length of the next two periods. A flag clear is judged by sampling the flag after the edge. A cycle-accurate model in the bench also runs throughout a random phase, and there the same collisions happen by chance under changing prescaler and freeze settings.

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
  parameter int CW = 16,
  parameter int SW = 2,
  parameter int LW = 3,
  parameter logic [CW-1:0] RST_PER = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic [SW-1:0] presc_sel,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          wr32_en,
  input  logic [2*CW-1:0] wr32_data,
  output logic          pwm_out,
  output logic [CW-1:0] count,
  output logic          flag,
  output logic          irq,
  output logic [LW-1:0] irq_level
);
  localparam int FLAG_BIT = LW;

  logic [SW-1:0] pcnt;
  logic [CW-1:0] stg_per, stg_w, act_per, act_w;
  logic [LW-1:0] lvl;

  wire tick    = pcnt >= presc_sel;
  wire advance = tick & ~freeze;
  wire wrap    = advance & (count == act_per - 1'b1);
  wire reload  = wrap & ~wr32_en;
  wire ctl_wr  = wr_en & (wr_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pcnt <= '0;
    else if (!freeze) pcnt <= tick ? '0 : pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       count <= '0;
    else if (advance) count <= wrap ? '0 : count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stg_per <= RST_PER;
      stg_w   <= '0;
    end else if (wr32_en) begin
      stg_per <= wr32_data[2*CW-1:CW];
      stg_w   <= wr32_data[CW-1:0];
    end else if (wr_en && wr_addr == 2'd0) stg_per <= wr_data;
    else if (wr_en && wr_addr == 2'd1)     stg_w   <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_per <= RST_PER;
      act_w   <= '0;
    end else if (reload) begin
      act_per <= stg_per;
      act_w   <= stg_w;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lvl <= '0;
    else if (ctl_wr) lvl <= wr_data[LW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          flag <= 1'b0;
    else if (wrap)                       flag <= 1'b1;
    else if (ctl_wr && !wr_data[FLAG_BIT]) flag <= 1'b0;

  assign pwm_out   = count < act_w;
  assign irq       = flag & (|lvl);
  assign irq_level = irq ? lvl : '0;

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap) |=> count == CW'($past(count) + 1'b1));
  a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_per) && $stable(act_w)));
  a_r6_skip_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && wr32_en) |=> ($stable(act_per) && $stable(act_w)));
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(count) && $stable(pcnt)));
endmodule

// File: tb/pwm_dbuf_test.sv
`timescale 1ns/1ps
module pwm_dbuf_test;
  logic clk = 0, rst_n = 0, freeze = 0, wr_en = 0, wr32_en = 0;
  logic [1:0] presc_sel = 0, wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [31:0] wr32_data = 0;
  logic pwm_out, flag, irq;
  logic [15:0] count;
  logic [2:0] irq_level;
  int checks = 0, errors = 0;
  bit lock_on = 0, done = 0;

  pwm_dbuf uut (.clk(clk), .rst_n(rst_n), .freeze(freeze), .presc_sel(presc_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr32_en(wr32_en),
    .wr32_data(wr32_data), .pwm_out(pwm_out), .count(count), .flag(flag),
    .irq(irq), .irq_level(irq_level));

  always #2 clk = ~clk;

  logic [1:0] m_pc;
  logic [15:0] m_cnt, m_sp, m_sw, m_ap, m_aw;
  logic m_flag;
  logic [2:0] m_lvl;

  function automatic bit m_exp_pwm(input logic [15:0] c, input logic [15:0] w);
    return c < w;
  endfunction
  function automatic logic [2:0] m_exp_lvl(input logic f, input logic [2:0] l);
    return (f && l != 0) ? l : 3'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_sp = 16; m_sw = 0; m_ap = 16; m_aw = 0;
      m_flag = 0; m_lvl = 0;
    end else begin
      logic tk, act, bnd;
      logic [15:0] osp, osw;
      tk = (m_pc >= presc_sel);
      act = tk && !freeze;
      bnd = act && (m_cnt == 16'(m_ap - 1));
      osp = m_sp; osw = m_sw;
      if (!freeze) m_pc = tk ? 2'd0 : m_pc + 2'd1;
      if (act) m_cnt = bnd ? 16'd0 : m_cnt + 16'd1;
      if (bnd && !wr32_en) begin m_ap = osp; m_aw = osw; end
      if (wr32_en) begin m_sp = wr32_data[31:16]; m_sw = wr32_data[15:0]; end
      else if (wr_en && wr_addr == 0) m_sp = wr_data;
      else if (wr_en && wr_addr == 1) m_sw = wr_data;
      if (wr_en && wr_addr == 2) m_lvl = wr_data[2:0];
      if (bnd) m_flag = 1;
      else if (wr_en && wr_addr == 2 && !wr_data[3]) m_flag = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (lock_on) begin
    chk(count == m_cnt, "R2 count", count, m_cnt);
    chk(pwm_out == m_exp_pwm(m_cnt, m_aw), "R3 pwm_out", pwm_out, m_exp_pwm(m_cnt, m_aw));
    chk(flag == m_flag, "R7 flag", flag, m_flag);
    chk(irq_level == m_exp_lvl(m_flag, m_lvl), "R8 irq_level", irq_level, m_exp_lvl(m_flag, m_lvl));
    chk(irq == (m_flag && m_lvl != 0), "R8 irq", irq, m_flag && m_lvl != 0);
  end

  task automatic w16(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic w32(input logic [15:0] p, input logic [15:0] w);
    wr32_en = 1; wr32_data = {p, w};
    @(negedge clk); wr32_en = 0;
  endtask
  task automatic measure(output int len, output int hi);
    while (count == 0) @(negedge clk);
    while (count != 0) @(negedge clk);
    len = 0; hi = 0;
    do begin hi += pwm_out; len++; @(negedge clk); end while (count != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, hi, c0, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
    chk(flag == 0 && irq == 0, "R1 flag/irq", flag, 0);
    chk(count == 0, "R1 count", count, 0);
    rst_n = 1;
    @(negedge clk);
    lock_on = 1;
    measure(len, hi);
    chk(len == 16 && hi == 0, "R1 reset period", len, 16);

    presc_sel = 3;
    c0 = count; n = 0;
    while (count == c0) @(negedge clk);
    c0 = count;
    while (count == c0) begin n++; @(negedge clk); end
    chk(n == 4, "R10 divide by 4", n, 4);
    presc_sel = 0;
    repeat (2) @(negedge clk);

    while (count != 3) @(negedge clk);
    w16(1, 8);
    while (count != 0) begin chk(pwm_out == 0, "R4 mid-period", pwm_out, 0); @(negedge clk); end
    measure(len, hi);
    chk(len == 16 && hi == 8, "R4 width loaded", hi, 8);

    while (count != 5) @(negedge clk);
    w32(10, 3);
    measure(len, hi);
    chk(len == 10 && hi == 3, "R5 pair loaded", len * 100 + hi, 1003);

    while (count != 9) @(negedge clk);
    w32(12, 5);
    c0 = 0;
    len = 0; hi = 0;
    do begin hi += pwm_out; len++; @(negedge clk); end while (count != 0);
    chk(len == 10 && hi == 3, "R6 skipped reload", len * 100 + hi, 1003);
    len = 0; hi = 0;
    do begin hi += pwm_out; len++; @(negedge clk); end while (count != 0);
    chk(len == 12 && hi == 5, "R6 delayed load", len * 100 + hi, 1205);

    while (count != 4) @(negedge clk);
    w16(1, 0);
    measure(len, hi);
    chk(len == 12 && hi == 0, "R3 zero duty", hi, 0);
    while (count != 4) @(negedge clk);
    w16(1, 20);
    measure(len, hi);
    chk(len == 12 && hi == 12, "R3 full duty", hi, 12);
    measure(len, hi);
    chk(len == 12, "R3 counter runs at full duty", len, 12);

    while (count != 3) @(negedge clk);
    chk(flag == 1, "R7 flag set", flag, 1);
    w16(2, 16'h0008);
    chk(flag == 1, "R7 bit3=1 keeps flag", flag, 1);
    w16(2, 16'h0000);
    chk(flag == 0, "R7 flag cleared", flag, 0);
    chk(irq == 0, "R8 level zero no irq", irq, 0);
    while (count != 11) @(negedge clk);
    w16(2, 16'h0005);
    chk(flag == 1, "R7 boundary beats clear", flag, 1);
    chk(irq == 1 && irq_level == 5, "R8 irq level 5", irq_level, 5);

    freeze = 1;
    c0 = count;
    repeat (10) begin @(negedge clk); chk(count == c0, "R9 frozen", count, c0); end
    freeze = 0;
    @(negedge clk);
    chk(count == 16'((c0 + 1) % 12), "R9 resume", count, (c0 + 1) % 12);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) presc_sel = 2'($urandom_range(0, 3));
      if (r >= 3 && r < 8) freeze = ~freeze;
      if (r >= 8 && r < 11) w32(16'($urandom_range(2, 14)), 16'($urandom_range(0, 16)));
      else if (r >= 11 && r < 14) w16(2'($urandom_range(0, 1)), 16'($urandom_range(2, 14)));
      else if (r >= 14 && r < 17) w16(2, 16'($urandom_range(0, 15)));
      else @(negedge clk);
    end
    freeze = 0;
    lock_on = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule